// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block is the configuration-space front end of a legacy I/O controller. It watches byte writes and reads on a host I/O bus. While locked it ignores everything except a four-byte key written to one of two base ports. The last key byte depends on which base port carries the sequence. Once the key is complete, the controller is unlocked on that base port. The base port then acts as an index latch, and the port one above it acts as the data window into an indexed register file.

The register file holds a read-only two-byte chip identity, a logical-device select, a global flash-control byte and a bank of port-base register pairs, one pair per logical device. The pair belonging to the flash logical device drives the flash controller's port base. The global byte drives the suspend flag, the segment enables, the host-write enable and the pin select. A fixed exit command written through the data window locks the controller again. Read data is registered and appears on the cycle after the read strobe.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: The byte writes 0x87, 0x01, 0x55, 0x55 to base port 0x2E, in that order, set `cfg_unlocked` after the edge that takes the fourth byte.
- R2: On base port 0x4E the fourth key byte must be 0xAA. A fourth byte of 0x55 on 0x4E, or 0xAA on 0x2E, leaves the block locked.
- R3: A byte that does not match the expected key byte, or that arrives on the other base port, returns the matcher to its start. A mismatching byte equal to 0x87 counts as a new first byte on the port it arrived at.
- R4: While locked, a read of either data port returns 0xFF, and writes to the data ports change no register.
- R5: While unlocked, a write to the unlocked base port sets the index, and index-addressed reads and writes go through base+1. The other base pair is ignored: its data port reads 0xFF and its writes change nothing.
- R6: Index 0x20 reads 0x87 and index 0x21 reads 0x16, and writes to these indices have no effect.
- R7: Writing 0x02 at index 0x02 clears `cfg_unlocked` after the edge that takes the write. Any other value written at index 0x02 leaves the block unlocked.
- R8: Index 0x24 stores bits 5:0 and reads bits 7:6 as zero. Bit 0 drives `flash_suspend`, bits 3:1 drive `flash_seg_en[2:0]`, bit 4 drives `flash_host_wr_en` and bit 5 drives `flash_pin_alt`.
- R9: Index 0x07 holds the logical-device number. Indices 0x64 (high byte) and 0x65 (low byte) are banked per logical device. `flash_port_base` shows the pair of logical device 7.
- R10: With a logical-device number of 8 or more selected, writes at 0x64 and 0x65 are ignored and reads at these indices return 0xFF.
- R11: A synchronous active-high reset clears the unlock state, the index latch, the logical-device number and every stored register to zero.
- R12: `io_rdata` is loaded on the edge that samples `io_rd`. A read of any address other than the unlocked data port returns 0xFF, and unimplemented indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host byte write strobe, one cycle per access |
| io_rd | input | 1 | Host byte read strobe, one cycle per access |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read byte |
| cfg_unlocked | output | 1 | Configuration mode active |
| flash_port_base | output | 16 | Flash controller port base from logical device 7 |
| flash_seg_en | output | 3 | Flash address segment enables |
| flash_host_wr_en | output | 1 | Host writes to flash enabled |
| flash_pin_alt | output | 1 | Alternate pin selected for the serial flash signal |
| flash_suspend | output | 1 | Suspend flag |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle. They also assume that each strobe marks exactly one byte access, so every high cycle of `io_wr` counts as one key byte. The stimulus uses tasks that raise a single strobe for one cycle and then drop it, so both assumptions hold. Expected read bytes are queued when a read is issued and compared by a monitor on the cycle after the strobe. This checks the registered read timing together with the value.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

    localparam logic [7:0] KEY_FIRST   = 8'h87;
    localparam logic [7:0] KEY_SECOND  = 8'h01;
    localparam logic [7:0] KEY_THIRD   = 8'h55;
    localparam logic [7:0] KEY_LAST_A  = 8'h55;
    localparam logic [7:0] KEY_LAST_B  = 8'hAA;

    localparam logic [7:0] IDX_EXIT    = 8'h02;
    localparam logic [7:0] EXIT_VALUE  = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_GLOBAL  = 8'h24;
    localparam logic [7:0] IDX_BASE_HI = 8'h64;
    localparam logic [7:0] IDX_BASE_LO = 8'h65;

    localparam logic [7:0] ID_HI_VALUE = 8'h87;
    localparam logic [7:0] ID_LO_VALUE = 8'h16;

    localparam logic [7:0] FLOAT_BYTE  = 8'hFF;

    typedef struct packed {
        logic [1:0] step;
        logic       on_b;
    } key_state_t;

endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match
    import cfg_unlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       sel_b,
    input  logic [7:0] wdata,
    output logic       unlock_o,
    output logic       unlock_b_o
);

    key_state_t km_d, km_q;
    logic [7:0] expect_byte;

    always_comb begin
        km_d     = km_q;
        unlock_o = 1'b0;
        unique case (km_q.step)
            2'd1:    expect_byte = KEY_SECOND;
            2'd2:    expect_byte = KEY_THIRD;
            2'd3:    expect_byte = km_q.on_b ? KEY_LAST_B : KEY_LAST_A;
            default: expect_byte = KEY_FIRST;
        endcase
        if (wr_en) begin
            if (km_q.step == 2'd0) begin
                if (wdata == KEY_FIRST) begin
                    km_d.step = 2'd1;
                    km_d.on_b = sel_b;
                end
            end else if (sel_b == km_q.on_b && wdata == expect_byte) begin
                if (km_q.step == 2'd3) begin
                    unlock_o  = 1'b1;
                    km_d.step = 2'd0;
                end else begin
                    km_d.step = km_q.step + 2'd1;
                end
            end else if (wdata == KEY_FIRST) begin
                km_d.step = 2'd1;
                km_d.on_b = sel_b;
            end else begin
                km_d.step = 2'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) km_q <= '0;
        else     km_q <= km_d;
    end

    assign unlock_b_o = km_q.on_b;

    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(km_q.step)); // R3

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_unlock_pkg::*;
#(
    parameter int NUM_LDN   = 8,
    parameter int FLASH_LDN = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [15:0] flash_port_base,
    output logic [5:0]  global_bits
);

    localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

    typedef struct packed {
        logic [7:0]                ldn;
        logic [5:0]                glob;
        logic [NUM_LDN-1:0][7:0]   bank_hi;
        logic [NUM_LDN-1:0][7:0]   bank_lo;
    } rf_state_t;

    rf_state_t rf_d, rf_q;
    logic             ldn_ok;
    logic [LDN_W-1:0] ldn_sel;
    logic [NUM_LDN-1:0] bank_hit;

    assign ldn_ok  = (int'(rf_q.ldn) < NUM_LDN);
    assign ldn_sel = rf_q.ldn[LDN_W-1:0];

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank_sel
        assign bank_hit[g] = ldn_ok && (ldn_sel == LDN_W'(g));
    end

    always_comb begin
        rf_d = rf_q;
        if (wr_en) begin
            unique case (idx)
                IDX_LDN:    rf_d.ldn  = wdata;
                IDX_GLOBAL: rf_d.glob = wdata[5:0];
                IDX_BASE_HI: begin
                    for (int i = 0; i < NUM_LDN; i++)
                        if (bank_hit[i]) rf_d.bank_hi[i] = wdata;
                end
                IDX_BASE_LO: begin
                    for (int i = 0; i < NUM_LDN; i++)
                        if (bank_hit[i]) rf_d.bank_lo[i] = wdata;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_LDN:     rdata = rf_q.ldn;
            IDX_ID_HI:   rdata = ID_HI_VALUE;
            IDX_ID_LO:   rdata = ID_LO_VALUE;
            IDX_GLOBAL:  rdata = {2'b00, rf_q.glob};
            IDX_BASE_HI: rdata = ldn_ok ? rf_q.bank_hi[ldn_sel] : FLOAT_BYTE;
            IDX_BASE_LO: rdata = ldn_ok ? rf_q.bank_lo[ldn_sel] : FLOAT_BYTE;
            default:     rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rf_q <= '0;
        else     rf_q <= rf_d;
    end

    assign flash_port_base = {rf_q.bank_hi[FLASH_LDN], rf_q.bank_lo[FLASH_LDN]};
    assign global_bits     = rf_q.glob;

    AST_BANK_OOR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ldn_ok) |=> ($stable(rf_q.bank_hi) && $stable(rf_q.bank_lo))); // R10

endmodule

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
    import cfg_unlock_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     BASE_A    = 16'h002E,
    parameter logic [15:0]     BASE_B    = 16'h004E,
    parameter int              NUM_LDN   = 8,
    parameter int              FLASH_LDN = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_unlocked,
    output logic [15:0]       flash_port_base,
    output logic [2:0]        flash_seg_en,
    output logic              flash_host_wr_en,
    output logic              flash_pin_alt,
    output logic              flash_suspend
);

    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(BASE_A);
    localparam logic [ADDR_W-1:0] PORT_B = ADDR_W'(BASE_B);

    typedef struct packed {
        logic       unlocked;
        logic       on_b;
        logic [7:0] idx;
        logic [7:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              hit_a, hit_b, key_wr;
    logic              unlock_pulse, unlock_b;
    logic [ADDR_W-1:0] idx_port, data_port;
    logic              data_wr;
    logic [7:0]        reg_rdata;
    logic [5:0]        global_bits;

    assign hit_a     = (io_addr == PORT_A);
    assign hit_b     = (io_addr == PORT_B);
    assign key_wr    = io_wr && !st_q.unlocked && (hit_a || hit_b);
    assign idx_port  = st_q.on_b ? PORT_B : PORT_A;
    assign data_port = idx_port + ADDR_W'(1);
    assign data_wr   = st_q.unlocked && io_wr && (io_addr == data_port);

    cfg_key_match u_key (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (key_wr),
        .sel_b      (hit_b),
        .wdata      (io_wdata),
        .unlock_o   (unlock_pulse),
        .unlock_b_o (unlock_b)
    );

    cfg_regfile #(
        .NUM_LDN   (NUM_LDN),
        .FLASH_LDN (FLASH_LDN)
    ) u_regs (
        .clk             (clk),
        .rst             (rst),
        .wr_en           (data_wr),
        .idx             (st_q.idx),
        .wdata           (io_wdata),
        .rdata           (reg_rdata),
        .flash_port_base (flash_port_base),
        .global_bits     (global_bits)
    );

    always_comb begin
        st_d = st_q;
        if (unlock_pulse) begin
            st_d.unlocked = 1'b1;
            st_d.on_b     = unlock_b;
        end
        if (st_q.unlocked && io_wr && (io_addr == idx_port))
            st_d.idx = io_wdata;
        if (data_wr && st_q.idx == IDX_EXIT && io_wdata == EXIT_VALUE)
            st_d.unlocked = 1'b0;
        if (io_rd)
            st_d.rdata = (st_q.unlocked && io_addr == data_port) ? reg_rdata : FLOAT_BYTE;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign io_rdata         = st_q.rdata;
    assign cfg_unlocked     = st_q.unlocked;
    assign flash_suspend    = global_bits[0];
    assign flash_seg_en     = global_bits[3:1];
    assign flash_host_wr_en = global_bits[4];
    assign flash_pin_alt    = global_bits[5];

    AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_unlocked) |-> ($past(io_wr) &&
            ($past(io_wdata) == KEY_LAST_A || $past(io_wdata) == KEY_LAST_B))); // R1

    AST_EXIT_CMD: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_unlocked) |-> ($past(rst) ||
            ($past(io_wr) && $past(io_wdata) == EXIT_VALUE))); // R7

    AST_LOCKED_READ: assert property (@(posedge clk) disable iff (rst)
        (!cfg_unlocked && io_rd) |=> (io_rdata == FLOAT_BYTE)); // R4

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_unlocked |=> ($stable(flash_port_base) && $stable(global_bits))); // R4

endmodule

// File: tb/cfg_unlock_ctrl_tb.sv
module cfg_unlock_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_unlocked;
    logic [15:0] flash_port_base;
    logic [2:0]  flash_seg_en;
    logic        flash_host_wr_en;
    logic        flash_pin_alt;
    logic        flash_suspend;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    cfg_unlock_ctrl u_dut (
        .clk              (clk),
        .rst              (rst),
        .io_wr            (io_wr),
        .io_rd            (io_rd),
        .io_addr          (io_addr),
        .io_wdata         (io_wdata),
        .io_rdata         (io_rdata),
        .cfg_unlocked     (cfg_unlocked),
        .flash_port_base  (flash_port_base),
        .flash_seg_en     (flash_seg_en),
        .flash_host_wr_en (flash_host_wr_en),
        .flash_pin_alt    (flash_pin_alt),
        .flash_suspend    (flash_suspend)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= io_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected read", 32'(io_rdata), 32'hDEAD);
            end else begin
                check(tag_q.pop_front(), 32'(io_rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic key(input logic [15:0] a, input logic [7:0] last);
        wr(a, 8'h87); wr(a, 8'h01); wr(a, 8'h55); wr(a, last);
    endtask

    task automatic reg_wr(input logic [15:0] base, input logic [7:0] i, input logic [7:0] d);
        wr(base, i); wr(base + 16'd1, d);
    endtask

    task automatic reg_rd(input logic [15:0] base, input logic [7:0] i, input logic [7:0] e, input string tag);
        wr(base, i); rd(base + 16'd1, e, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset unlocked", 32'(cfg_unlocked), 0);
        check("R11 reset flash base", 32'(flash_port_base), 0);
        rd(16'h2F, 8'hFF, "R4 locked read");

        // locked writes must not land
        wr(16'h2E, 8'h24); wr(16'h2F, 8'h3F);
        check("R4 locked write outputs", 32'({flash_pin_alt, flash_host_wr_en, flash_seg_en, flash_suspend}), 0);

        key(16'h2E, 8'hAA);
        check("R2 AA on 2E stays locked", 32'(cfg_unlocked), 0);
        key(16'h2E, 8'h55);
        check("R1 unlock on 2E", 32'(cfg_unlocked), 1);
        reg_rd(16'h2E, 8'h24, 8'h00, "R4 locked write ignored");

        reg_rd(16'h2E, 8'h20, 8'h87, "R6 id high");
        reg_rd(16'h2E, 8'h21, 8'h16, "R6 id low");
        reg_wr(16'h2E, 8'h20, 8'h00);
        reg_rd(16'h2E, 8'h20, 8'h87, "R6 id read-only");

        reg_wr(16'h2E, 8'h24, 8'hFF);
        rd(16'h2F, 8'h3F, "R8 global upper bits zero");
        check("R8 outputs all set", 32'({flash_pin_alt, flash_host_wr_en, flash_seg_en, flash_suspend}), 32'h3F);
        reg_wr(16'h2E, 8'h24, 8'h2A);
        check("R8 suspend", 32'(flash_suspend), 0);
        check("R8 seg enables", 32'(flash_seg_en), 5);
        check("R8 host write", 32'(flash_host_wr_en), 0);
        check("R8 pin select", 32'(flash_pin_alt), 1);

        reg_wr(16'h2E, 8'h07, 8'h07);
        reg_wr(16'h2E, 8'h64, 8'h12);
        reg_wr(16'h2E, 8'h65, 8'h34);
        check("R9 flash base", 32'(flash_port_base), 32'h1234);
        reg_wr(16'h2E, 8'h07, 8'h03);
        reg_wr(16'h2E, 8'h64, 8'hAB);
        rd(16'h2F, 8'hAB, "R9 bank of ldn 3");
        check("R9 flash base unaffected", 32'(flash_port_base), 32'h1234);
        reg_rd(16'h2E, 8'h07, 8'h03, "R9 ldn readback");
        reg_wr(16'h2E, 8'h07, 8'h07);
        reg_rd(16'h2E, 8'h64, 8'h12, "R9 bank of ldn 7");
        reg_rd(16'h2E, 8'h65, 8'h34, "R9 bank low of ldn 7");

        reg_wr(16'h2E, 8'h07, 8'h09);
        reg_wr(16'h2E, 8'h64, 8'h55);
        rd(16'h2F, 8'hFF, "R10 out of range read");
        check("R10 flash base kept", 32'(flash_port_base), 32'h1234);
        reg_wr(16'h2E, 8'h07, 8'h07);
        reg_rd(16'h2E, 8'h64, 8'h12, "R10 ldn 7 untouched");

        rd(16'h4F, 8'hFF, "R5 other data port");
        wr(16'h4E, 8'h24); wr(16'h4F, 8'h00);
        reg_rd(16'h2E, 8'h24, 8'h2A, "R5 other pair ignored");
        rd(16'h2E, 8'hFF, "R12 index port read");
        reg_rd(16'h2E, 8'h40, 8'h00, "R12 unimplemented index");

        reg_wr(16'h2E, 8'h02, 8'h01);
        check("R7 other value stays unlocked", 32'(cfg_unlocked), 1);
        wr(16'h2F, 8'h02);
        check("R7 exit relocks", 32'(cfg_unlocked), 0);
        rd(16'h2F, 8'hFF, "R4 read after relock");

        wr(16'h4E, 8'h87); wr(16'h4E, 8'h01);
        key(16'h4E, 8'hAA);
        check("R3 restart on 87", 32'(cfg_unlocked), 1);
        reg_rd(16'h4E, 8'h21, 8'h16, "R5 pair at 4E");
        rd(16'h2F, 8'hFF, "R5 2F ignored when on 4E");
        reg_wr(16'h4E, 8'h02, 8'h02);
        check("R7 relock on 4E", 32'(cfg_unlocked), 0);

        wr(16'h4E, 8'h87); wr(16'h4E, 8'h01); wr(16'h4E, 8'h00);
        wr(16'h4E, 8'h55); wr(16'h4E, 8'hAA);
        check("R3 wrong byte resets", 32'(cfg_unlocked), 0);
        wr(16'h2E, 8'h87); wr(16'h4E, 8'h01); wr(16'h4E, 8'h55); wr(16'h4E, 8'hAA);
        check("R3 port switch resets", 32'(cfg_unlocked), 0);
        key(16'h4E, 8'h55);
        check("R2 55 on 4E stays locked", 32'(cfg_unlocked), 0);

        key(16'h4E, 8'hAA);
        check("R2 unlock on 4E", 32'(cfg_unlocked), 1);
        reg_wr(16'h4E, 8'h07, 8'h05);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R11 reset relocks", 32'(cfg_unlocked), 0);
        check("R11 reset clears base", 32'(flash_port_base), 0);
        check("R11 reset clears global", 32'({flash_pin_alt, flash_host_wr_en, flash_seg_en, flash_suspend}), 0);
        key(16'h2E, 8'h55);
        rd(16'h2F, 8'h00, "R11 index cleared");
        reg_rd(16'h2E, 8'h07, 8'h00, "R11 ldn cleared");

        repeat (3) @(negedge clk);
        check("R12 all reads returned", 32'(exp_q.size()), 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule